// File: doc/BRIEF.md
# Asynchronous Host Bus Slave with Wait Stretching

This block sits at the device side of a generic microprocessor bus. The host presents a 21-bit address and a memory/register space select. It frames a transfer with an active-low chip select and drives one active-low read strobe and one active-low write strobe for each byte lane of a 16-bit data bus. The block turns each host cycle into exactly one single-cycle request on an internal access port. That request carries the address, the space select, a write flag, the byte enables and, for writes, the write data. The block holds the host off with an active-low WAIT line until the port acknowledges.

All host control inputs are asynchronous. They pass through two-flop synchronizers on the bus clock before the cycle state machine sees them, so a cycle starts on the first bus clock edges after the strobes become valid. WAIT is driven only while the host selects the block. It is released by driving it high for one clock and then floating it. Read data is driven onto the bus only while a read strobe is held, and it is valid before WAIT goes high. If the host gives up before the acknowledge arrives, the cycle is abandoned quietly.

Top module: `mpu_wait_slave`

## Requirements
- R1: A change on chip select or any strobe takes effect only after two synchronizer flops. A cycle whose strobe falls before rising edge 1 raises `req_valid` in the interval after rising edge 3, and not earlier.
- R2: WAIT is driven low (`wait_oe`=1, `wait_n_o`=0) in idle whenever the synchronized chip select is low, and throughout the wait for the acknowledge.
- R3: Each cycle produces `req_valid` for exactly one clock. The request carries the address, the space select and the write flag (1 = write), with `req_be` bit 0 for lane [7:0] and bit 1 for lane [15:8]. A lane is enabled when its synchronized strobe is low. If read and write strobes are low together, the read takes priority.
- R4: For a write, `req_wdata` holds the bus data of the enabled lanes, sampled at the request edge, and zero in the disabled lanes.
- R5: For a read, `data_oe` is high from the request until the synchronized read strobes are all high. `bus_data_o` is zero before the acknowledge. After the acknowledge it holds `ack_rdata` in the enabled lanes and zero in the others.
- R6: After an acknowledge, WAIT is driven high for exactly one clock and then is no longer driven high.
- R7: If all strobes, or chip select, go high before the acknowledge, the block returns to idle. It issues no further request and never drives WAIT high for that cycle. An acknowledge that arrives in idle is ignored.
- R8: After the release, no new request is issued while the strobes stay low. A new cycle needs all strobes, or chip select, to go high first.
- R9: During and right after reset, `wait_oe`, `data_oe` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 21 | Host address |
| bus_mr | input | 1 | Space select, 1 = memory, 0 = registers |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_rd_n | input | 2 | Active-low read strobe per byte lane |
| bus_wr_n | input | 2 | Active-low write strobe per byte lane |
| bus_data_i | input | 16 | Data from the host |
| bus_data_o | output | 16 | Read data to the host |
| bus_data_oe | output | 1 | Data output enable |
| wait_n_o | output | 1 | WAIT level when driven |
| wait_oe | output | 1 | WAIT output enable |
| req_valid | output | 1 | Single-cycle internal request |
| req_addr | output | 21 | Request address |
| req_mr | output | 1 | Request space select |
| req_write | output | 1 | 1 = write request |
| req_be | output | 2 | Request byte enables |
| req_wdata | output | 16 | Request write data |
| ack | input | 1 | Internal access complete |
| ack_rdata | input | 16 | Read data returned with the acknowledge |

## Verification
Every output decodes the cycle state directly, so a wrong state shows at the ports within one clock. A missed abort leaves WAIT driven after the strobes rise. A lost acknowledge leaves WAIT stuck low. A state that re-enters the start condition shows up as a second `req_valid` pulse. Lane mistakes show up in `req_be`, in `req_wdata` or in the read bytes. The bench models the synchronizers and cycle phases on its own and compares all of these on every clock, so a divergence is reported on the cycle where it first appears.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_WAIT = 2'd1,
    CYC_REL  = 2'd2,
    CYC_DONE = 2'd3
  } cyc_state_e;

  // true when any bit of an active-low strobe vector is asserted
  function automatic logic any_low2(input logic [1:0] v);
    return (v != 2'b11);
  endfunction
endpackage

// File: rtl/mpu_sync.sv
module mpu_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      q  <= '1;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/mpu_cycle_fsm.sv
module mpu_cycle_fsm
  import mpu_bus_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic [LANES-1:0] rd_s,
  input  logic [LANES-1:0] wr_s,
  input  logic             ack,
  output cyc_state_e       state,
  output logic             ev_start,
  output logic             ev_abort,
  output logic             ev_ack_take,
  output logic             req_pulse
);
  logic active;
  cyc_state_e nxt;

  assign active      = !cs_s && ((rd_s != '1) || (wr_s != '1));
  assign ev_start    = (state == CYC_IDLE) && active;
  assign ev_abort    = (state == CYC_WAIT) && !active;
  assign ev_ack_take = (state == CYC_WAIT) && active && ack;

  always_comb begin
    nxt = state;
    unique case (state)
      CYC_IDLE: if (active) nxt = CYC_WAIT;
      CYC_WAIT: begin
        if (!active) nxt = CYC_IDLE;
        else if (ack) nxt = CYC_REL;
      end
      CYC_REL:  nxt = active ? CYC_DONE : CYC_IDLE;
      CYC_DONE: if (!active) nxt = CYC_IDLE;
      default:  nxt = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CYC_IDLE;
      req_pulse <= 1'b0;
    end else begin
      state     <= nxt;
      req_pulse <= ev_start;
    end
  end
endmodule

// File: rtl/mpu_lane_path.sv
module mpu_lane_path #(
  parameter int ADDR_W = 21,
  parameter int LANES  = 2,
  localparam int DW    = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_ack_take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              mr_in,
  input  logic [LANES-1:0]  rd_s,
  input  logic [LANES-1:0]  wr_s,
  input  logic [DW-1:0]     wdata_in,
  input  logic [DW-1:0]     rdata_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              mr_q,
  output logic              write_q,
  output logic [LANES-1:0]  be_q,
  output logic [DW-1:0]     wdata_q,
  output logic [DW-1:0]     rdata_q
);
  // expand byte enables into a bit mask
  function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  logic             is_write;
  logic [LANES-1:0] be_now;

  assign is_write = (rd_s == '1);
  assign be_now   = is_write ? ~wr_s : ~rd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      mr_q    <= 1'b0;
      write_q <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (ev_start) begin
      addr_q  <= addr_in;
      mr_q    <= mr_in;
      write_q <= is_write;
      be_q    <= be_now;
      wdata_q <= wdata_in & lane_mask(be_now);
      rdata_q <= '0;
    end else if (ev_ack_take) begin
      rdata_q <= rdata_in & lane_mask(be_q);
    end
  end
endmodule

// File: rtl/mpu_wait_slave.sv
module mpu_wait_slave
  import mpu_bus_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int LANES  = 2,
  localparam int DW    = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_mr,
  input  logic              bus_cs_n,
  input  logic [LANES-1:0]  bus_rd_n,
  input  logic [LANES-1:0]  bus_wr_n,
  input  logic [DW-1:0]     bus_data_i,
  output logic [DW-1:0]     bus_data_o,
  output logic              bus_data_oe,
  output logic              wait_n_o,
  output logic              wait_oe,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_mr,
  output logic              req_write,
  output logic [LANES-1:0]  req_be,
  output logic [DW-1:0]     req_wdata,
  input  logic              ack,
  input  logic [DW-1:0]     ack_rdata
);
  localparam int SW = 1 + 2 * LANES;

  logic [SW-1:0]    sync_q;
  logic             cs_s;
  logic [LANES-1:0] rd_s, wr_s;
  cyc_state_e       state;
  logic             ev_start, ev_abort, ev_ack_take;

  mpu_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_cs_n, bus_rd_n, bus_wr_n}),
    .q(sync_q)
  );
  assign {cs_s, rd_s, wr_s} = sync_q;

  mpu_cycle_fsm #(.LANES(LANES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rd_s(rd_s), .wr_s(wr_s),
    .ack(ack), .state(state), .ev_start(ev_start), .ev_abort(ev_abort),
    .ev_ack_take(ev_ack_take), .req_pulse(req_valid)
  );

  mpu_lane_path #(.ADDR_W(ADDR_W), .LANES(LANES)) u_path (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_ack_take(ev_ack_take),
    .addr_in(bus_addr), .mr_in(bus_mr), .rd_s(rd_s), .wr_s(wr_s),
    .wdata_in(bus_data_i), .rdata_in(ack_rdata),
    .addr_q(req_addr), .mr_q(req_mr), .write_q(req_write), .be_q(req_be),
    .wdata_q(req_wdata), .rdata_q(bus_data_o)
  );

  assign wait_oe     = ((state == CYC_IDLE) && !cs_s) ||
                       (state == CYC_WAIT) || (state == CYC_REL);
  assign wait_n_o    = (state == CYC_REL);
  assign bus_data_oe = !req_write && (state != CYC_IDLE) && (rd_s != '1);
endmodule

// File: rtl/mpu_wait_slave_chk.sv
module mpu_wait_slave_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LANES-1:0] req_be,
  input logic             req_write,
  input logic             wait_oe,
  input logic             wait_n_o,
  input logic             bus_data_oe,
  input logic             ack,
  input logic             ev_abort
);
  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  p_req_has_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_be != '0));

  p_rel_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_oe && wait_n_o) |-> $past(ack));

  p_rel_one_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_oe && wait_n_o) |=> !(wait_oe && wait_n_o));

  p_drive_only_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> !req_write);

  p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !(wait_oe && wait_n_o) && !req_valid);
endmodule

bind mpu_wait_slave mpu_wait_slave_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_be(req_be),
  .req_write(req_write), .wait_oe(wait_oe), .wait_n_o(wait_n_o),
  .bus_data_oe(bus_data_oe), .ack(ack), .ev_abort(ev_abort)
);

// File: tb/mpu_wait_slave_tb_top.sv
module mpu_wait_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] bus_addr = '0;
  logic        bus_mr = 1'b0;
  logic        bus_cs_n = 1'b1;
  logic [1:0]  bus_rd_n = 2'b11;
  logic [1:0]  bus_wr_n = 2'b11;
  logic [15:0] bus_data_i = '0;
  logic [15:0] bus_data_o;
  logic        bus_data_oe, wait_n_o, wait_oe, req_valid, req_mr, req_write;
  logic [20:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        ack = 1'b0;
  logic [15:0] ack_rdata = '0;

  always #10 clk = ~clk;

  mpu_wait_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_mr(bus_mr),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_data_i(bus_data_i), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .wait_n_o(wait_n_o), .wait_oe(wait_oe), .req_valid(req_valid),
    .req_addr(req_addr), .req_mr(req_mr), .req_write(req_write),
    .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .ack_rdata(ack_rdata)
  );

  integer errors = 0, checks = 0, cycles = 0, req_count = 0, rel_count = 0;
  bit     done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [4:0]  m1 = 5'h1F, m2 = 5'h1F;
  int          mst = 0;
  bit          mreq = 0, mwrite = 0, mmr = 0;
  logic [1:0]  mbe = 0;
  logic [20:0] maddr = 0;
  logic [15:0] mwdata = 0, mrdata = 0;

  function automatic logic [15:0] bytes_of(input logic [1:0] be);
    return {be[1] ? 8'hFF : 8'h00, be[0] ? 8'hFF : 8'h00};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 5'h1F; m2 = 5'h1F; mst = 0; mreq = 0;
      mwrite = 0; mmr = 0; mbe = 0; maddr = 0; mwdata = 0; mrdata = 0;
    end else begin
      logic cs; logic [1:0] rd, wr; bit act;
      cs = m2[4]; rd = m2[3:2]; wr = m2[1:0];
      act = !cs && (rd != 2'b11 || wr != 2'b11);
      mreq = 0;
      if (mst == 0) begin
        if (act) begin
          mst = 1; mreq = 1; mwrite = (rd == 2'b11);
          mbe = mwrite ? ~wr : ~rd;
          maddr = bus_addr; mmr = bus_mr;
          mwdata = bus_data_i & bytes_of(mbe); mrdata = 0;
        end
      end else if (mst == 1) begin
        if (!act) mst = 0;
        else if (ack) begin mrdata = ack_rdata & bytes_of(mbe); mst = 2; end
      end else if (mst == 2) mst = act ? 3 : 0;
      else if (!act) mst = 0;
      m2 = m1; m1 = {bus_cs_n, bus_rd_n, bus_wr_n};
    end
  end

  // ---------------- every-clock comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ewoe, edoe;
      ewoe = (mst == 0 && !m2[4]) || mst == 1 || mst == 2;
      edoe = !mwrite && mst != 0 && m2[3:2] != 2'b11;
      check("R2 wait_oe", wait_oe, ewoe);
      if (ewoe) check("R6 wait level", wait_n_o, mst == 2);
      check("R5 data_oe", bus_data_oe, edoe);
      if (edoe) check("R5 read data", bus_data_o, mrdata);
      check("R3 req_valid", req_valid, mreq);
      if (mreq) begin
        check("R3 req_addr", req_addr, maddr);
        check("R3 req_mr", req_mr, mmr);
        check("R3 req_write", req_write, mwrite);
        check("R3 req_be", req_be, mbe);
        if (mwrite) check("R4 req_wdata", req_wdata, mwdata);
      end
      if (req_valid) req_count++;
      if (wait_oe && wait_n_o) rel_count++;
    end
  end

  // ---------------- acknowledge responder ----------------
  integer ack_delay = 0, pend = -1;
  bit     force_ack = 0;
  always @(negedge clk) begin
    ack = force_ack;
    if (req_valid && ack_delay >= 0) pend = ack_delay;
    if (pend == 0) begin ack = 1; pend = -1; end
    else if (pend > 0) pend--;
  end

  // ---------------- watchdog ----------------
  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_cycle(input logic [1:0] rd, input logic [1:0] wr,
                             input logic [20:0] a, input logic m, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_mr = m; bus_data_i = d;
    bus_cs_n = 0; bus_rd_n = rd; bus_wr_n = wr;
  endtask

  task automatic end_cycle;
    @(negedge clk);
    bus_cs_n = 1; bus_rd_n = 2'b11; bus_wr_n = 2'b11;
    cyc(4);
  endtask

  task automatic wait_release;
    do @(negedge clk); while (!(wait_oe && wait_n_o));
  endtask

  initial begin
    int rq0, rl0;
    cyc(3);
    check("R9 wait_oe in reset", wait_oe, 0);
    check("R9 data_oe in reset", bus_data_oe, 0);
    check("R9 req_valid in reset", req_valid, 0);
    @(negedge clk) rst_n = 1;
    cyc(2);
    check("R9 wait_oe after reset", wait_oe, 0);
    check("R9 req_valid after reset", req_valid, 0);

    // R1/R3/R4: full-width write, sync latency
    ack_delay = 3;
    begin_cycle(2'b11, 2'b00, 21'h1ABCD, 1'b1, 16'hA55A);
    @(negedge clk); check("R1 no req after edge 1", req_valid, 0);
    @(negedge clk); check("R1 no req after edge 2", req_valid, 0);
    @(negedge clk); check("R1 req after edge 3", req_valid, 1);
    wait_release;
    end_cycle;

    // R4: low lane write only
    ack_delay = 1;
    begin_cycle(2'b11, 2'b10, 21'h00012, 1'b0, 16'hC33C);
    wait_release;
    end_cycle;

    // R5: high lane read
    ack_delay = 2; ack_rdata = 16'h1234;
    begin_cycle(2'b01, 2'b11, 21'h10000, 1'b1, 16'h0);
    wait_release;
    check("R5 high lane data", bus_data_o, 16'h1200);
    end_cycle;

    // R5: full read, immediate acknowledge
    ack_delay = 0; ack_rdata = 16'hBEEF;
    begin_cycle(2'b00, 2'b11, 21'h0F0F0, 1'b0, 16'h0);
    wait_release;
    check("R5 full read data", bus_data_o, 16'hBEEF);
    end_cycle;

    // R3: read and write strobes together, read wins
    ack_delay = 1; ack_rdata = 16'h7788;
    begin_cycle(2'b10, 2'b00, 21'h00777, 1'b1, 16'hFFFF);
    wait_release;
    check("R3 read priority data", bus_data_o, 16'h0088);
    end_cycle;

    // R7: abort before acknowledge, late acknowledge ignored
    ack_delay = -1; rq0 = req_count; rl0 = rel_count;
    begin_cycle(2'b00, 2'b11, 21'h00AAA, 1'b0, 16'h0);
    cyc(6);
    @(negedge clk); bus_cs_n = 1; bus_rd_n = 2'b11;
    cyc(5);
    force_ack = 1; cyc(1); force_ack = 0; cyc(4);
    check("R7 one request on abort", req_count - rq0, 1);
    check("R7 no release on abort", rel_count - rl0, 0);
    check("R7 wait floats after abort", wait_oe, 0);

    // R8: strobes held long after release
    ack_delay = 2; rq0 = req_count;
    begin_cycle(2'b11, 2'b01, 21'h15555, 1'b1, 16'h9876);
    wait_release;
    cyc(12);
    check("R8 single request while held", req_count - rq0, 1);
    check("R6 wait floats after release", wait_oe, 0);
    end_cycle;

    // R8: back-to-back cycle after strobes rise
    ack_delay = 1; rq0 = req_count;
    begin_cycle(2'b11, 2'b00, 21'h00001, 1'b0, 16'h1111);
    wait_release;
    end_cycle;
    check("R8 new cycle gives new request", req_count - rq0, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule